// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block makes the keep-or-drop decision for each received CAN frame. On every frame-valid strobe it takes the frame's identifier, which may be standard or extended, and extracts the eight bits that lead the identifier. It compares those bits against eight independent filters. Each filter has its own code byte and its own don't-care mask byte. One cycle later it reports which filters matched and the lowest-numbered match. If any filter matched, it also raises an accept pulse.

A second mode shuts the filter completely, so that no frame is ever accepted. A sticky receive-full flag is set by every accepted frame and is cleared by a write-one-to-clear input. The mode, the identifier and the filter settings are all captured at the strobe, so changes made between frames cannot disturb a decision that has already been reported.

Top module: `can_af_top`

## Requirements
- R1: The leading byte of the identifier is id_i[10:3] when id_ext_i=0 (standard, 11 bits) and id_i[28:21] when id_ext_i=1 (extended, 29 bits). No other identifier bit affects any output.
- R2: Filter n uses code byte code_i[8n+7:8n] and mask byte mask_i[8n+7:8n]. A mask bit of 1 makes that identifier bit don't-care. Filter n matches when ((lead ^ code) & ~mask) == 0.
- R3: In the cycle after a strobe, bit n of hit_vec_o reports whether filter n matched. Any number of bits, from zero to eight, may be set together.
- R4: In eight-filter mode (mode_i=0), accept_o is high for exactly the one cycle after a strobe in which at least one filter matched. accept_o is low in every other cycle.
- R5: hit_idx_o gives the index of the lowest-numbered set bit of hit_vec_o, and is 0 when no bit is set.
- R6: In closed mode (mode_i=1), a strobe gives accept_o=0, hit_vec_o=0 and hit_idx_o=0, and it leaves rxf_o unchanged.
- R7: rxf_o is set in the same cycle that accept_o rises. It then stays set until a cycle with rxf_clr_i=1, after which it reads 0. If a clear and an accepted frame arrive in the same cycle, the set wins.
- R8: hit_vec_o and hit_idx_o hold their values until the next strobe. Changes to mode_i, id_i, id_ext_i, code_i or mask_i with no strobe leave every output unchanged.
- R9: While rst_ni is low, accept_o, hit_vec_o, hit_idx_o and rxf_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_vld_i | input | 1 | One-cycle strobe: a received identifier is present |
| id_ext_i | input | 1 | 1 = extended identifier, 0 = standard identifier |
| id_i | input | 29 | Received identifier, right-aligned |
| mode_i | input | 1 | 0 = eight 8-bit filters, 1 = closed |
| code_i | input | 64 | Eight code bytes, filter n in bits [8n+7:8n] |
| mask_i | input | 64 | Eight mask bytes, 1 = don't care |
| rxf_clr_i | input | 1 | Write-one-to-clear for the receive-full flag |
| accept_o | output | 1 | One-cycle accept pulse |
| hit_vec_o | output | 8 | Per-filter match vector |
| hit_idx_o | output | 3 | Lowest-numbered matching filter |
| rxf_o | output | 1 | Sticky receive-full flag |

## Verification
With random codes, the case that is hardest to produce is a frame that matches several filters at once while the lowest match sits above filter 0. Independent random code bytes almost never match a given leading byte. To reach it, the stimulus derives each filter's code from the frame's own leading byte with a coin flip per filter, and flips only bits that the mask hides. This produces frequent multi-hit vectors with a varied lowest index. Directed steps then cover a clear arriving in the same cycle as an accepted frame, standard identifiers whose unused upper bits carry garbage, and inputs that change with no strobe between frames.

// File: rtl/can_af_pkg.sv
package can_af_pkg;
  typedef enum logic {
    AF_MODE_OCT  = 1'b0,
    AF_MODE_SHUT = 1'b1
  } af_mode_e;

  localparam int unsigned AF_LEAD_W = 8;
endpackage

// File: rtl/can_af_lead.sv
module can_af_lead #(
  parameter int unsigned ID_W   = 29,
  parameter int unsigned STD_W  = 11,
  parameter int unsigned LEAD_W = 8
) (
  input  logic [ID_W-1:0]   id_i,
  input  logic              ext_i,
  output logic [LEAD_W-1:0] lead_o
);
  always_comb begin
    if (ext_i) lead_o = id_i[ID_W-1 -: LEAD_W];
    else       lead_o = id_i[STD_W-1 -: LEAD_W];
  end
endmodule

// File: rtl/can_af_match.sv
module can_af_match #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] lead_i,
  input  logic [W-1:0] code_i,
  input  logic [W-1:0] mask_i,
  output logic         hit_o
);
  logic [W-1:0] diff;
  assign diff  = (lead_i ^ code_i) & ~mask_i;
  assign hit_o = (diff == '0);
endmodule

// File: rtl/can_af_prienc.sv
module can_af_prienc #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/can_af_top.sv
module can_af_top
  import can_af_pkg::*;
#(
  parameter int unsigned NUM_FILT = 8,
  parameter int unsigned ID_W     = 29,
  parameter int unsigned STD_W    = 11,
  localparam int unsigned LW      = AF_LEAD_W,
  localparam int unsigned IDX_W   = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frame_vld_i,
  input  logic                   id_ext_i,
  input  logic [ID_W-1:0]        id_i,
  input  logic                   mode_i,
  input  logic [NUM_FILT*LW-1:0] code_i,
  input  logic [NUM_FILT*LW-1:0] mask_i,
  input  logic                   rxf_clr_i,
  output logic                   accept_o,
  output logic [NUM_FILT-1:0]    hit_vec_o,
  output logic [IDX_W-1:0]       hit_idx_o,
  output logic                   rxf_o
);
  af_mode_e          mode;
  logic [LW-1:0]     lead;
  logic [NUM_FILT-1:0] hit_raw;
  logic [NUM_FILT-1:0] hit_gated;
  logic [IDX_W-1:0]  idx_raw;
  logic              take;

  assign mode = af_mode_e'(mode_i);

  can_af_lead #(.ID_W(ID_W), .STD_W(STD_W), .LEAD_W(LW)) u_lead (
    .id_i   (id_i),
    .ext_i  (id_ext_i),
    .lead_o (lead)
  );

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
    can_af_match #(.W(LW)) u_match (
      .lead_i (lead),
      .code_i (code_i[g*LW +: LW]),
      .mask_i (mask_i[g*LW +: LW]),
      .hit_o  (hit_raw[g])
    );
  end

  // closed mode blanks every filter
  assign hit_gated = (mode == AF_MODE_SHUT) ? '0 : hit_raw;

  can_af_prienc #(.N(NUM_FILT)) u_enc (
    .req_i (hit_gated),
    .idx_o (idx_raw)
  );

  assign take = frame_vld_i && (hit_gated != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o  <= 1'b0;
      hit_vec_o <= '0;
      hit_idx_o <= '0;
    end else begin
      accept_o <= take;
      if (frame_vld_i) begin
        hit_vec_o <= hit_gated;
        hit_idx_o <= idx_raw;
      end
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rxf_o <= 1'b0;
    else if (take)      rxf_o <= 1'b1;
    else if (rxf_clr_i) rxf_o <= 1'b0;
  end
endmodule

// File: rtl/can_af_chk.sv
module can_af_chk #(
  parameter int unsigned NUM_FILT = 8,
  localparam int unsigned IDX_W   = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                frame_vld_i,
  input logic                mode_i,
  input logic                rxf_clr_i,
  input logic                accept_o,
  input logic [NUM_FILT-1:0] hit_vec_o,
  input logic [IDX_W-1:0]    hit_idx_o,
  input logic                rxf_o
);
  AST_ACCEPT_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> !accept_o); // R4
  AST_ACCEPT_HAS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (hit_vec_o != '0)); // R3
  AST_IDX_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (hit_vec_o[hit_idx_o] &&
      ((hit_vec_o & ((NUM_FILT'(1) << hit_idx_o) - NUM_FILT'(1))) == '0))); // R5
  AST_CLOSED_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && mode_i) |=> (!accept_o && hit_vec_o == '0)); // R6
  AST_CLOSED_NO_RXF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rxf_o && mode_i) |=> !rxf_o); // R6
  AST_RXF_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> rxf_o); // R7
  AST_RXF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxf_o && !rxf_clr_i) |=> rxf_o); // R7
  AST_RXF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxf_clr_i && !frame_vld_i) |=> !rxf_o); // R7
  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> ($stable(hit_vec_o) && $stable(hit_idx_o))); // R8
endmodule

bind can_af_top can_af_chk #(.NUM_FILT(NUM_FILT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_vld_i (frame_vld_i),
  .mode_i      (mode_i),
  .rxf_clr_i   (rxf_clr_i),
  .accept_o    (accept_o),
  .hit_vec_o   (hit_vec_o),
  .hit_idx_o   (hit_idx_o),
  .rxf_o       (rxf_o)
);

// File: tb/can_af_top_tb_top.sv
module can_af_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic        ext = 1'b0;
  logic [28:0] id = '0;
  logic        mode = 1'b0;
  logic [63:0] code = '0;
  logic [63:0] mask = '0;
  logic        clr = 1'b0;
  logic        acc;
  logic [7:0]  hv;
  logic [2:0]  hi;
  logic        rxf;

  int checks = 0;
  int fails  = 0;
  logic exp_rxf = 1'b0;

  always #5 clk = ~clk;

  can_af_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_vld_i(vld), .id_ext_i(ext), .id_i(id),
    .mode_i(mode), .code_i(code), .mask_i(mask), .rxf_clr_i(clr),
    .accept_o(acc), .hit_vec_o(hv), .hit_idx_o(hi), .rxf_o(rxf)
  );

  function automatic logic [7:0] f_lead(logic [28:0] i, logic e);
    return e ? i[28:21] : i[10:3];
  endfunction

  function automatic logic [7:0] f_hits(logic [7:0] l, logic [63:0] c, logic [63:0] m, logic md);
    logic [7:0] h = '0;
    if (md) return 8'h00;
    for (int n = 0; n < 8; n++) h[n] = (((l ^ c[8*n +: 8]) & ~m[8*n +: 8]) == 8'h00);
    return h;
  endfunction

  function automatic logic [2:0] f_idx(logic [7:0] h);
    for (int n = 0; n < 8; n++) if (h[n]) return 3'(n);
    return 3'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one strobe and check the cycle after it
  task automatic frame(string req, logic [28:0] i, logic e, logic md, logic cl);
    logic [7:0] eh;
    @(negedge clk);
    id = i; ext = e; mode = md; clr = cl; vld = 1'b1;
    eh = f_hits(f_lead(i, e), code, mask, md);
    @(negedge clk);
    vld = 1'b0; clr = 1'b0;
    if (eh != 0) exp_rxf = 1'b1;
    else if (cl) exp_rxf = 1'b0;
    chk({req, " accept"}, 32'(acc), 32'(eh != 0));
    chk({req, " hit_vec"}, 32'(hv), 32'(eh));
    chk({req, " hit_idx"}, 32'(hi), 32'(f_idx(eh)));
    chk({req, " rxf"}, 32'(rxf), 32'(exp_rxf));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] sv_hv;
    logic [2:0] sv_hi;
    void'($urandom(32'h5EED_CA11));
    #12;
    chk("R9 accept", 32'(acc), 0);
    chk("R9 hit_vec", 32'(hv), 0);
    chk("R9 rxf", 32'(rxf), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: exact match on filter 3, mask don't-care on filter 6
    code = '0; mask = '0;
    code[8*3 +: 8] = 8'hA5;
    code[8*6 +: 8] = 8'h00; mask[8*6 +: 8] = 8'hFF;
    for (int n = 0; n < 8; n++) if (n != 3 && n != 6) code[8*n +: 8] = 8'h5A;
    frame("R2", {18'h0, 8'hA5, 3'b101}, 1'b0, 1'b0, 1'b0);
    // R1: standard, garbage in unused upper bits
    frame("R1 std", {18'h3FFFF, 8'hA5, 3'b010}, 1'b0, 1'b0, 1'b0);
    // R1: extended lead byte
    frame("R1 ext", {8'hA5, 21'h1ABCD}, 1'b1, 1'b0, 1'b0);
    // R3/R5: multi-hit, lowest index 2
    code = {8{8'h3C}}; mask = '0;
    code[8*0 +: 8] = 8'h00; code[8*1 +: 8] = 8'hC3;
    frame("R3 R5 multi", {8'h3C, 21'h0}, 1'b1, 1'b0, 1'b0);
    // R4: no hit
    frame("R4 nohit", {8'h11, 21'h0}, 1'b1, 1'b0, 1'b0);
    chk("R7 sticky", 32'(rxf), 1);
    // R7: clear then set-vs-clear collision
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; exp_rxf = 1'b0;
    chk("R7 clear", 32'(rxf), 0);
    frame("R7 collide", {8'h3C, 21'h0}, 1'b1, 1'b0, 1'b1);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; exp_rxf = 1'b0;
    // R6: closed with all-don't-care filters
    mask = '1;
    frame("R6 closed", {8'h3C, 21'h0}, 1'b1, 1'b1, 1'b0);
    // R8: hold after a hit, then disturb inputs with no strobe
    mask = '0;
    frame("R8 base", {8'h3C, 21'h0}, 1'b1, 1'b0, 1'b0);
    sv_hv = hv; sv_hi = hi;
    @(negedge clk);
    chk("R4 single cycle", 32'(acc), 0);
    id = '1; mode = 1'b1; code = '0; mask = '1; ext = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 hit_vec hold", 32'(hv), 32'(sv_hv));
    chk("R8 hit_idx hold", 32'(hi), 32'(sv_hi));
    chk("R8 accept", 32'(acc), 0);

    // random with codes biased toward the frame's lead byte
    for (int k = 0; k < 400; k++) begin
      logic [28:0] ri;
      logic re, rm, rc;
      logic [7:0] ld;
      ri = 29'($urandom); re = 1'($urandom);
      rm = (($urandom % 8) == 0);
      rc = (($urandom % 4) == 0);
      ld = f_lead(ri, re);
      for (int n = 0; n < 8; n++) begin
        logic [7:0] mb;
        mb = 8'($urandom) & 8'($urandom);
        mask[8*n +: 8] = mb;
        code[8*n +: 8] = $urandom_range(1, 0) ? (ld ^ (8'($urandom) & mb)) : 8'($urandom);
      end
      frame("R3 R4 R5 R6 R7 rand", ri, re, rm, rc);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule